// File: doc/BRIEF.md
# Switchable CPU Clock Selector

This block derives every clock a small 8-bit microcomputer needs from a single fast reference. The peripherals get a system clock at one quarter of the reference rate, and this clock does not depend on the speed setting. The CPU clock pin gets one of two rates. In normal mode it gets half the reference rate. In double mode it gets the reference itself. The reference is nominally 9.8304 MHz, so the system clock is about 2.45 MHz and the CPU clock is about 4.9 or 9.8 MHz.

Software selects the speed by writing to I/O port 0x85. Data value 1 asks for double speed and data value 0 asks for normal speed. Normal speed stays available for programs that rely on software timing loops. Double speed makes screen-bound programs more responsive. A second input can be driven by the chip select of a peripheral that cannot keep up with the fast CPU clock. While that input is high, the CPU runs at normal speed, whatever mode is latched. The CPU clock changes rate only at an instant when both candidate clocks are low, so it never produces a short high or low pulse.

Top module: `cpuclk_switch`

## Requirements
- R1: While reset is active, the latched mode is normal and the system clock is low. After reset is released, the CPU clock follows the half-rate clock, whose first rising edge comes at the first reference rising edge.
- R2: The system clock is the reference divided by 4. It is high for two reference periods and then low for two, in every mode and with or without the override.
- R3: While normal mode is in force, the CPU clock toggles at every reference rising edge, which gives half the reference rate.
- R4: While double mode is in force, the CPU clock equals the reference clock.
- R5: A write with the strobe high to address 0x85 latches data bit 0 into the mode at the next reference rising edge. A value of 1 means double speed and 0 means normal speed.
- R6: Data bits 7 to 1 of a mode write have no effect. For example, 0xFE selects normal speed and 0x03 selects double speed.
- R7: A write to any address other than 0x85, or any bus activity with the strobe low, leaves the mode unchanged.
- R8: After the override input has passed through its synchronizer (2 reference cycles by default), normal mode is in force from the next switching point onward. Once the override is released, the latched mode returns at the next switching point after the same delay.
- R9: The mode in force changes only at a reference falling edge at which the half-rate clock is low. As a result, every CPU clock high phase and low phase lasts at least half a reference period.
- R10: The status output shows the mode that is in force on the CPU clock (1 = double). That mode is the latched mode ANDed with the inverted synchronized override, taken at the last switching point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 8 | I/O write address |
| io_data | input | 8 | I/O write data; only bit 0 is used |
| io_wr | input | 1 | I/O write strobe, active high |
| slow_req | input | 1 | Override input: forces normal speed while high |
| cpu_clk | output | 1 | Clock for the CPU, at full or half reference rate |
| sys_clk | output | 1 | Fixed-rate system clock, reference divided by 4 |
| fast_active | output | 1 | 1 while double speed is in force on cpu_clk |

## Verification
The bench uses the default parameter values: a port address of 0x85, a two-stage override synchronizer and a system clock divider of 4. With these values, a mode write and a change of the override both meet each phase of the half-rate clock, so the bench reaches switching points that are delayed by one extra reference cycle as well as points that are not. The bench compares all outputs in both halves of every reference period. This comparison shows whether the CPU clock equals the reference or the half-rate clock, and it catches any change of rate at a point where a candidate clock is high.

// File: rtl/ckdbl_pkg.sv
package ckdbl_pkg;
   typedef enum logic {
      SPD_NORMAL = 1'b0,
      SPD_DOUBLE = 1'b1
   } speed_e;

   function automatic speed_e effective_speed(input speed_e latched, input logic forced_slow);
      return (forced_slow) ? SPD_NORMAL : latched;
   endfunction
endpackage

// File: rtl/ckdbl_mode_latch.sv
module ckdbl_mode_latch
   import ckdbl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h85
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output speed_e            mode_o
);
   logic hit;

   assign hit = wr_en && (addr == PORT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= SPD_NORMAL;
      end else if (hit) begin
         mode_o <= data[0] ? SPD_DOUBLE : SPD_NORMAL;
      end
   end
endmodule

// File: rtl/ckdbl_sync.sv
module ckdbl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d;
         end
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], d};
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ckdbl_divider.sv
module ckdbl_divider #(
   parameter int unsigned DIV_LOG2 = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [DIV_LOG2-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/ckdbl_cpu_sel.sv
module ckdbl_cpu_sel
   import ckdbl_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  speed_e want,
   input  logic   half_clk,
   output logic   cpu_clk_o,
   output logic   fast_o
);
   // Select flop updates on the falling reference edge, only while the
   // half-rate clock is low: both inputs of the gate are then low.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_o <= 1'b0;
      end else if (!half_clk) begin
         fast_o <= (want == SPD_DOUBLE);
      end
   end

   assign cpu_clk_o = (clk & fast_o) | (half_clk & ~fast_o);
endmodule

// File: rtl/cpuclk_switch.sv
module cpuclk_switch
   import ckdbl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h85,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SYS_DIV_LOG2 = 2
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_data,
   input  logic              io_wr,
   input  logic              slow_req,
   output logic              cpu_clk,
   output logic              sys_clk,
   output logic              fast_active
);
   localparam int unsigned SYS_MSB = SYS_DIV_LOG2 - 1;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (SYS_DIV_LOG2 < 1) begin : g_bad_div
         $error("SYS_DIV_LOG2 must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   speed_e              mode_q;
   logic                ovr_s;
   logic [SYS_MSB:0]    div_cnt;
   logic                half_clk;
   speed_e              want;

   ckdbl_mode_latch #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PORT_ADDR(PORT_ADDR)
   ) mode_i (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .wr_en (io_wr),
      .addr  (io_addr),
      .data  (io_data),
      .mode_o(mode_q)
   );

   ckdbl_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk_ref),
      .rst_n(rst_n),
      .d    (slow_req),
      .q    (ovr_s)
   );

   ckdbl_divider #(.DIV_LOG2(SYS_DIV_LOG2)) div_i (
      .clk  (clk_ref),
      .rst_n(rst_n),
      .cnt_o(div_cnt)
   );

   assign half_clk = div_cnt[0];
   assign sys_clk  = div_cnt[SYS_MSB];
   assign want     = effective_speed(mode_q, ovr_s);

   ckdbl_cpu_sel sel_i (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .want     (want),
      .half_clk (half_clk),
      .cpu_clk_o(cpu_clk),
      .fast_o   (fast_active)
   );
endmodule

// File: rtl/cpuclk_switch_chk.sv
module cpuclk_switch_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h85
) (
   input logic              clk_ref,
   input logic              rst_n,
   input logic              io_wr,
   input logic [ADDR_W-1:0] io_addr,
   input logic [DATA_W-1:0] io_data,
   input logic              mode_bit,
   input logic              ovr_s,
   input logic              half_clk,
   input logic              fast,
   input logic              sys_clk
);
   // R2: each system clock level lasts two reference cycles
   a_r2_sys_half: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (sys_clk != $past(sys_clk)) |=> $stable(sys_clk));

   // R5: a matching write latches bit 0
   a_r5_latch: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (io_wr && io_addr == PORT_ADDR) |=> (mode_bit == $past(io_data[0])));

   // R7: no matching write, mode holds
   a_r7_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !(io_wr && io_addr == PORT_ADDR) |=> $stable(mode_bit));

   // R9: the select moves only while the half-rate clock is low
   a_r9_safe_switch: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (fast != $past(fast)) |-> !half_clk);

   // R8: synchronized override forces normal at a switching point
   a_r8_override_slow: assert property (@(negedge clk_ref) disable iff (!rst_n)
      (!half_clk && ovr_s) |=> !fast);

   // R10: at a switching point the applied mode becomes latched AND NOT override
   a_r10_applied: assert property (@(negedge clk_ref) disable iff (!rst_n)
      !half_clk |=> (fast == $past(mode_bit && !ovr_s)));
endmodule

bind cpuclk_switch cpuclk_switch_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .PORT_ADDR(PORT_ADDR)
) chk_i (
   .clk_ref (clk_ref),
   .rst_n   (rst_n),
   .io_wr   (io_wr),
   .io_addr (io_addr),
   .io_data (io_data),
   .mode_bit(mode_q == ckdbl_pkg::SPD_DOUBLE),
   .ovr_s   (ovr_s),
   .half_clk(half_clk),
   .fast    (fast_active),
   .sys_clk (sys_clk)
);

// File: tb/cpuclk_switch_tb.sv
module cpuclk_switch_tb_top;
   localparam int CLK_PERIOD = 20;
   localparam int STAGES     = 2;
   localparam logic [7:0] PORT = 8'h85;

   logic       clk_ref = 1'b0;
   logic       rst_n   = 1'b0;
   logic [7:0] io_addr = 8'h00;
   logic [7:0] io_data = 8'h00;
   logic       io_wr   = 1'b0;
   logic       slow_req = 1'b0;
   logic       cpu_clk, sys_clk, fast_active;

   int total = 0;
   int bad   = 0;
   string phase_req = "R1";

   cpuclk_switch #(.SYNC_STAGES(STAGES)) dut_i (
      .clk_ref    (clk_ref),
      .rst_n      (rst_n),
      .io_addr    (io_addr),
      .io_data    (io_data),
      .io_wr      (io_wr),
      .slow_req   (slow_req),
      .cpu_clk    (cpu_clk),
      .sys_clk    (sys_clk),
      .fast_active(fast_active)
   );

   always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

   // behavioural reference model
   int   ticks = 0;
   bit   m_mode = 0;
   bit   m_sel  = 0;
   bit   ovr_q[$];
   bit   m_ovr;

   initial begin
      for (int i = 0; i < STAGES; i++) ovr_q.push_back(1'b0);
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s at %0t: actual=%0d expected=%0d", req, what, $time, act, exp);
      end
   endtask

   always @(posedge clk_ref) begin
      if (rst_n) begin
         ticks++;
         if (io_wr && io_addr == PORT) m_mode = io_data[0];
         ovr_q.push_back(slow_req);
         void'(ovr_q.pop_front());
      end
      m_ovr = ovr_q[0];
      #5;
      check("R2", "sys_clk", sys_clk, (ticks / 2) % 2);
      check(m_sel ? "R4" : "R3", "cpu_clk(high ref)", cpu_clk, m_sel ? 1 : ticks % 2);
      check("R10", "fast_active", fast_active, m_sel);
      if (phase_req != "R1")
         check(phase_req, "scenario fast_active", fast_active, m_sel);
   end

   always @(negedge clk_ref) begin
      if (rst_n && (ticks % 2 == 0)) m_sel = m_mode & ~m_ovr;
      #5;
      check("R9", "cpu_clk(low ref)", cpu_clk, m_sel ? 0 : ticks % 2);
      check("R2", "sys_clk(low ref)", sys_clk, (ticks / 2) % 2);
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk_ref);
      #3;
   endtask

   task automatic bus(input logic [7:0] a, input logic [7:0] d, input logic w);
      io_addr = a; io_data = d; io_wr = w;
      @(posedge clk_ref); #3;
      io_wr = 1'b0; io_addr = 8'h00; io_data = 8'h00;
   endtask

   initial begin
      fork
         begin
            #(CLK_PERIOD * 3 + 7);
            check("R1", "reset sys_clk", sys_clk, 0);
            check("R1", "reset fast_active", fast_active, 0);
            check("R1", "reset cpu_clk", cpu_clk, 0);
            @(posedge clk_ref); #3;
            rst_n = 1'b1;
            idle(8);
            phase_req = "R5";
            bus(PORT, 8'h01, 1'b1); idle(6);
            check("R5", "double after write 1", fast_active, 1);
            bus(PORT, 8'h00, 1'b1); idle(6);
            check("R5", "normal after write 0", fast_active, 0);
            phase_req = "R6";
            bus(PORT, 8'h03, 1'b1); idle(6);
            check("R6", "0x03 gives double", fast_active, 1);
            bus(PORT, 8'hFE, 1'b1); idle(6);
            check("R6", "0xFE gives normal", fast_active, 0);
            bus(PORT, 8'hFF, 1'b1); idle(1);
            bus(PORT, 8'h01, 1'b1); idle(6);
            phase_req = "R7";
            bus(8'h84, 8'h00, 1'b1); idle(3);
            bus(8'h05, 8'h00, 1'b1); idle(3);
            bus(PORT, 8'h00, 1'b0); idle(6);
            check("R7", "mode unchanged", fast_active, 1);
            phase_req = "R8";
            slow_req = 1'b1; idle(7);
            check("R8", "override forces normal", fast_active, 0);
            bus(PORT, 8'h01, 1'b1); idle(5);
            check("R8", "still normal under override", fast_active, 0);
            slow_req = 1'b0; idle(7);
            check("R8", "release restores double", fast_active, 1);
            // short pulses on each half-rate phase
            slow_req = 1'b1; idle(1); slow_req = 1'b0; idle(6);
            bus(PORT, 8'h00, 1'b1); idle(1);
            slow_req = 1'b1; idle(2); slow_req = 1'b0; idle(1);
            bus(PORT, 8'h01, 1'b1); idle(9);
            phase_req = "R4";
            idle(20);
            phase_req = "R3";
            bus(PORT, 8'h00, 1'b1); idle(20);
         end
         begin
            #(CLK_PERIOD * 100000);
            bad++; total++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule